// File: doc/BRIEF.md
# Prefix-switched opcode decoder

This block decodes the leading bytes of each instruction for a 24-bit accumulator machine. Fetch presents the first two bytes of an instruction together with a valid strobe. One cycle later the decoder reports the instruction length, its format class and an operation code. It also reports which opcode map produced the result, the two register fields of a register-form instruction, and a one-cycle flag for an opcode that neither map defines.

Two opcode maps share the same byte space. The byte 0xEE is a one-byte prefix. It makes the extended map govern the next instruction that is decoded, and only that one. The same opcode byte, for example 0x90, is a scalar register add in the base map and a vector register add in the extended map. A halt opcode in the base map freezes the decoder until reset. Address calculation, operand fetch and execution happen in later stages.

Top module: `pfx_opdec`

## Requirements
- R1: An accepted byte 0xEE is a prefix. It reports op 1, format 0, length 1, and dec_ext equal to whether a prefix was already pending. The extended map then governs the next non-prefix decode only, however many idle cycles pass before it. A prefix that arrives while one is already pending keeps the extended map selected and is not flagged invalid.
- R2: In the base map, byte 0xF1 is a no-operation (op 2) and byte 0xF2 is a halt (op 3). Both report format 0 and length 1. The extended map holds neither.
- R3: A decoded halt raises `stopped` on the same edge that presents the halt result. `stopped` then stays high until reset. While it is high, in_valid is ignored and dec_valid stays low.
- R4: The map first looks up the full first byte among its one-byte and two-byte entries. If no entry matches, it clears the low two bits (mask 0xFC) and looks up the result among its long-format entries.
- R5: A two-byte instruction reports format 1 and length 2, with dec_r1 = byte1[7:4] and dec_r2 = byte1[3:0]. For every other format both register fields are 0.
- R6: A long-format instruction reports format 2. Its length is 4 when byte1 bit 4 is set and 3 otherwise.
- R7: Base map ops:
  - Two-byte forms: 0x90, 0x94, 0x98, 0x9C, 0xA0, 0xAC, 0xB4 and 0xB8 give ops 4 to 11 in that order.
  - Long forms (masked byte): 0x00, 0x18, 0x1C, 0x0C, 0x3C and 0x68 give ops 12 to 17 in that order.
- R8: Extended map ops:
  - Two-byte forms: 0x90, 0x94, 0x98 and 0x9C give ops 18 to 21.
  - Long forms (masked byte): 0x18, 0x1C, 0x20 and 0x24 give ops 22 to 25. Loads at 0x00, 0x68 and 0x04 give ops 26 to 28. Stores at 0x0C, 0x7C and 0x84 give ops 29 to 31.
- R9: A byte that the active map does not hold reports the following for one cycle: dec_valid 1, dec_invalid 1, format 3, length 1, op 0, and dec_ext naming the active map. It clears a pending prefix and changes no other state.
- R10: Reset clears the pending prefix and `stopped`, and drives every output to 0.
- R11: A pair accepted at a rising edge (in_valid high, `stopped` low) appears on the outputs after that edge for exactly one cycle. In every other cycle all decode outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction bytes present |
| in_byte0 | input | 8 | First instruction byte |
| in_byte1 | input | 8 | Second instruction byte |
| dec_valid | output | 1 | Decode result present |
| dec_len | output | 3 | Instruction length in bytes |
| dec_fmt | output | 2 | 0 one-byte, 1 two-byte, 2 long, 3 invalid |
| dec_op | output | 5 | Decoded operation code |
| dec_ext | output | 1 | Result came from the extended map |
| dec_r1 | output | 4 | First register field |
| dec_r2 | output | 4 | Second register field |
| dec_invalid | output | 1 | Opcode not defined in the active map |
| stopped | output | 1 | Halt seen; decoding frozen |

## Verification
The bench sweeps every first-byte value through both maps. A design that masked the addressing bits before the one-byte and two-byte lookup would turn 0x91 into a register add instead of an invalid opcode. Prefixes are sent back to back, and with idle gaps before the next instruction. A decoder that let the prefix expire early, or kept it after one use, would report the wrong map on the following byte. Halt behaviour is checked in both maps: a halt byte behind a prefix must be invalid, and a real halt must silence every later request until reset. A design that only blocked one cycle would produce results again.

// File: rtl/pfx_opdec_pkg.sv
package pfx_opdec_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int LEN_W  = 3;
  localparam int OP_W   = 5;
  localparam int EBIT   = 4;
  localparam logic [BYTE_W-1:0] PFX_BYTE = 8'hEE;
  localparam logic [BYTE_W-1:0] AM_MASK  = 8'hFC;

  typedef enum logic [1:0] {FMT_ONE, FMT_TWO, FMT_LONG, FMT_BAD} fmt_e;

  typedef enum logic [OP_W-1:0] {
    OP_NONE, OP_PREFIX, OP_NOP, OP_HALT,
    OP_RADD, OP_RSUB, OP_RMUL, OP_RDIV, OP_RCMP, OP_RMOV, OP_RCLR, OP_RSTEP,
    OP_LOAD_ACC, OP_MADD, OP_MSUB, OP_STORE_ACC, OP_JUMP, OP_LOAD_BASE,
    OP_VRADD, OP_VRSUB, OP_VRMUL, OP_VRDIV,
    OP_VMADD, OP_VMSUB, OP_VMMUL, OP_VMDIV,
    OP_VLD0, OP_VLD1, OP_VLD2, OP_VST0, OP_VST1, OP_VST2
  } op_e;

  typedef struct packed {
    logic hit;
    fmt_e fmt;
    op_e  op;
  } look_t;

  typedef struct packed {
    logic             valid;
    logic [LEN_W-1:0] len;
    fmt_e             fmt;
    op_e              op;
    logic             ext;
    logic [NIB_W-1:0] r1;
    logic [NIB_W-1:0] r2;
    logic             bad;
  } res_t;

  function automatic look_t hit_of(fmt_e f, op_e o);
    return '{hit: 1'b1, fmt: f, op: o};
  endfunction

  localparam look_t MISS = '{hit: 1'b0, fmt: FMT_BAD, op: OP_NONE};

  // full-byte entries of the base map
  function automatic look_t base_short(logic [BYTE_W-1:0] b);
    case (b)
      8'hF1: return hit_of(FMT_ONE, OP_NOP);
      8'hF2: return hit_of(FMT_ONE, OP_HALT);
      8'h90: return hit_of(FMT_TWO, OP_RADD);
      8'h94: return hit_of(FMT_TWO, OP_RSUB);
      8'h98: return hit_of(FMT_TWO, OP_RMUL);
      8'h9C: return hit_of(FMT_TWO, OP_RDIV);
      8'hA0: return hit_of(FMT_TWO, OP_RCMP);
      8'hAC: return hit_of(FMT_TWO, OP_RMOV);
      8'hB4: return hit_of(FMT_TWO, OP_RCLR);
      8'hB8: return hit_of(FMT_TWO, OP_RSTEP);
      default: return MISS;
    endcase
  endfunction

  // masked-byte entries of the base map
  function automatic look_t base_long(logic [BYTE_W-1:0] m);
    case (m)
      8'h00: return hit_of(FMT_LONG, OP_LOAD_ACC);
      8'h18: return hit_of(FMT_LONG, OP_MADD);
      8'h1C: return hit_of(FMT_LONG, OP_MSUB);
      8'h0C: return hit_of(FMT_LONG, OP_STORE_ACC);
      8'h3C: return hit_of(FMT_LONG, OP_JUMP);
      8'h68: return hit_of(FMT_LONG, OP_LOAD_BASE);
      default: return MISS;
    endcase
  endfunction

  function automatic look_t ext_short(logic [BYTE_W-1:0] b);
    case (b)
      8'h90: return hit_of(FMT_TWO, OP_VRADD);
      8'h94: return hit_of(FMT_TWO, OP_VRSUB);
      8'h98: return hit_of(FMT_TWO, OP_VRMUL);
      8'h9C: return hit_of(FMT_TWO, OP_VRDIV);
      default: return MISS;
    endcase
  endfunction

  function automatic look_t ext_long(logic [BYTE_W-1:0] m);
    case (m)
      8'h18: return hit_of(FMT_LONG, OP_VMADD);
      8'h1C: return hit_of(FMT_LONG, OP_VMSUB);
      8'h20: return hit_of(FMT_LONG, OP_VMMUL);
      8'h24: return hit_of(FMT_LONG, OP_VMDIV);
      8'h00: return hit_of(FMT_LONG, OP_VLD0);
      8'h68: return hit_of(FMT_LONG, OP_VLD1);
      8'h04: return hit_of(FMT_LONG, OP_VLD2);
      8'h0C: return hit_of(FMT_LONG, OP_VST0);
      8'h7C: return hit_of(FMT_LONG, OP_VST1);
      8'h84: return hit_of(FMT_LONG, OP_VST2);
      default: return MISS;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] instr_len(fmt_e f, logic ebit);
    case (f)
      FMT_TWO:  return LEN_W'(2);
      FMT_LONG: return ebit ? LEN_W'(4) : LEN_W'(3);
      default:  return LEN_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/pfx_map_lookup.sv
module pfx_map_lookup
  import pfx_opdec_pkg::*;
#(
  parameter bit EXT_MAP = 1'b0
) (
  input  logic [BYTE_W-1:0] byte0,
  output look_t             res
);
  look_t short_res;
  look_t long_res;
  logic [BYTE_W-1:0] masked;

  assign masked = byte0 & AM_MASK;

  generate
    if (EXT_MAP) begin : g_ext
      assign short_res = ext_short(byte0);
      assign long_res  = ext_long(masked);
    end else begin : g_base
      assign short_res = base_short(byte0);
      assign long_res  = base_long(masked);
    end
  endgenerate

  // full byte wins; masked lookup only on a miss
  assign res = short_res.hit ? short_res : long_res;
endmodule

// File: rtl/pfx_mode_ctl.sv
module pfx_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic pfx_evt,
  input  logic halt_evt,
  output logic pend_q,
  output logic stop_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (accept) pend_q <= pfx_evt;
      if (halt_evt) stop_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pfx_out_reg.sv
module pfx_out_reg
  import pfx_opdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  res_t nxt,
  output res_t cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end
endmodule

// File: rtl/pfx_opdec.sv
module pfx_opdec
  import pfx_opdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte0,
  input  logic [BYTE_W-1:0] in_byte1,
  output logic              dec_valid,
  output logic [LEN_W-1:0]  dec_len,
  output logic [1:0]        dec_fmt,
  output logic [OP_W-1:0]   dec_op,
  output logic              dec_ext,
  output logic [NIB_W-1:0]  dec_r1,
  output logic [NIB_W-1:0]  dec_r2,
  output logic              dec_invalid,
  output logic              stopped
);
  logic  pend_q, stop_q;
  logic  accept, is_pfx;
  logic  pfx_evt, halt_evt, bad_evt;
  look_t base_res, ext_res, sel;
  res_t  nxt, cur;

  pfx_map_lookup #(.EXT_MAP(1'b0)) u_base (.byte0(in_byte0), .res(base_res));
  pfx_map_lookup #(.EXT_MAP(1'b1)) u_ext  (.byte0(in_byte0), .res(ext_res));

  assign sel      = pend_q ? ext_res : base_res;
  assign accept   = in_valid & ~stop_q;
  assign is_pfx   = (in_byte0 == PFX_BYTE);
  assign pfx_evt  = accept & is_pfx;
  assign bad_evt  = accept & ~is_pfx & ~sel.hit;
  assign halt_evt = accept & ~is_pfx & sel.hit & (sel.op == OP_HALT);

  always_comb begin
    nxt = '0;
    if (accept) begin
      nxt.valid = 1'b1;
      nxt.ext   = pend_q;
      if (is_pfx) begin
        nxt.fmt = FMT_ONE;
        nxt.op  = OP_PREFIX;
        nxt.len = instr_len(FMT_ONE, 1'b0);
      end else if (sel.hit) begin
        nxt.fmt = sel.fmt;
        nxt.op  = sel.op;
        nxt.len = instr_len(sel.fmt, in_byte1[EBIT]);
        if (sel.fmt == FMT_TWO) begin
          nxt.r1 = in_byte1[BYTE_W-1:NIB_W];
          nxt.r2 = in_byte1[NIB_W-1:0];
        end
      end else begin
        nxt.fmt = FMT_BAD;
        nxt.op  = OP_NONE;
        nxt.len = instr_len(FMT_BAD, 1'b0);
        nxt.bad = 1'b1;
      end
    end
  end

  pfx_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pfx_evt(pfx_evt),
    .halt_evt(halt_evt), .pend_q(pend_q), .stop_q(stop_q)
  );

  pfx_out_reg u_out (.clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(cur));

  assign dec_valid   = cur.valid;
  assign dec_len     = cur.len;
  assign dec_fmt     = cur.fmt;
  assign dec_op      = cur.op;
  assign dec_ext     = cur.ext;
  assign dec_r1      = cur.r1;
  assign dec_r2      = cur.r2;
  assign dec_invalid = cur.bad;
  assign stopped     = stop_q;
endmodule

// File: rtl/pfx_opdec_chk.sv
module pfx_opdec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pend_q,
  input logic       stop_q,
  input logic       pfx_evt,
  input logic       halt_evt,
  input logic       bad_evt,
  input logic       dec_valid,
  input logic [2:0] dec_len,
  input logic [1:0] dec_fmt,
  input logic [4:0] dec_op,
  input logic       dec_ext,
  input logic [3:0] dec_r1,
  input logic [3:0] dec_r2,
  input logic       dec_invalid
);
  p_prefix_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_evt |=> pend_q);

  p_prefix_single_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op != 5'd1) |-> !pend_q);

  p_halt_sets_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> stop_q);

  p_stop_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> stop_q);

  p_quiet_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !dec_valid);

  p_two_byte_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_fmt == 2'd1) |-> dec_len == 3'd2);

  p_regs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fmt != 2'd1) |-> (dec_r1 == 4'd0 && dec_r2 == 4'd0));

  p_long_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_fmt == 2'd2) |-> (dec_len == 3'd3 || dec_len == 3'd4));

  p_bad_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_invalid |-> (dec_valid && dec_op == 5'd0 && dec_fmt == 2'd3 && dec_len == 3'd1));

  p_bad_clears_prefix_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (!pend_q && dec_invalid));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec_len == 3'd0 && dec_fmt == 2'd0 && dec_op == 5'd0 &&
                    !dec_ext && !dec_invalid));
endmodule

bind pfx_opdec pfx_opdec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .stop_q(stop_q),
  .pfx_evt(pfx_evt), .halt_evt(halt_evt), .bad_evt(bad_evt),
  .dec_valid(dec_valid), .dec_len(dec_len), .dec_fmt(dec_fmt),
  .dec_op(dec_op), .dec_ext(dec_ext), .dec_r1(dec_r1), .dec_r2(dec_r2),
  .dec_invalid(dec_invalid)
);

// File: tb/pfx_opdec_tb_top.sv
`timescale 1ns/1ps
module pfx_opdec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte0 = 8'h00;
  logic [7:0] in_byte1 = 8'h00;
  logic       dec_valid, dec_ext, dec_invalid, stopped;
  logic [2:0] dec_len;
  logic [1:0] dec_fmt;
  logic [4:0] dec_op;
  logic [3:0] dec_r1, dec_r2;

  always #2.5 clk = ~clk;

  pfx_opdec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte0(in_byte0),
    .in_byte1(in_byte1), .dec_valid(dec_valid), .dec_len(dec_len),
    .dec_fmt(dec_fmt), .dec_op(dec_op), .dec_ext(dec_ext), .dec_r1(dec_r1),
    .dec_r2(dec_r2), .dec_invalid(dec_invalid), .stopped(stopped)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference maps: byte -> op code
  int b_one[int], b_two[int], b_long[int], x_two[int], x_long[int];
  bit m_pend, m_stop;
  int e_valid, e_len, e_fmt, e_op, e_ext, e_r1, e_r2, e_inv;

  task automatic fill_maps();
    int bt[8] = '{'h90, 'h94, 'h98, 'h9C, 'hA0, 'hAC, 'hB4, 'hB8};
    int bl[6] = '{'h00, 'h18, 'h1C, 'h0C, 'h3C, 'h68};
    int xl[10] = '{'h18, 'h1C, 'h20, 'h24, 'h00, 'h68, 'h04, 'h0C, 'h7C, 'h84};
    b_one['hF1] = 2;
    b_one['hF2] = 3;
    foreach (bt[k]) b_two[bt[k]] = 4 + k;
    foreach (bl[k]) b_long[bl[k]] = 12 + k;
    for (int k = 0; k < 4; k++) x_two['h90 + 4*k] = 18 + k;
    foreach (xl[k]) x_long[xl[k]] = 22 + k;
  endtask

  task automatic compare(string tag);
    logic [22:0] got, exp;
    got = {dec_valid, dec_len, dec_fmt, dec_op, dec_ext, dec_r1, dec_r2, dec_invalid, stopped};
    exp = {e_valid[0], e_len[2:0], e_fmt[1:0], e_op[4:0], e_ext[0], e_r1[3:0],
           e_r2[3:0], e_inv[0], m_stop};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v%0d len%0d fmt%0d op%0d ext%0d r%0d/%0d inv%0d stop%0d, expected v%0d len%0d fmt%0d op%0d ext%0d r%0d/%0d inv%0d stop%0d",
               tag, dec_valid, dec_len, dec_fmt, dec_op, dec_ext, dec_r1, dec_r2,
               dec_invalid, stopped, e_valid, e_len, e_fmt, e_op, e_ext, e_r1,
               e_r2, e_inv, m_stop);
    end
  endtask

  // one cycle: called at a falling edge, returns at the next one
  task automatic cyc(bit v, int b0, int b1);
    string tag;
    in_valid = v;
    in_byte0 = b0[7:0];
    in_byte1 = b1[7:0];
    e_valid = 0; e_len = 0; e_fmt = 0; e_op = 0; e_ext = 0; e_r1 = 0; e_r2 = 0; e_inv = 0;
    tag = "R11";
    if (v && m_stop) tag = "R3";
    if (v && !m_stop) begin
      e_valid = 1;
      e_ext = m_pend;
      if (b0 == 'hEE) begin
        tag = "R1"; e_len = 1; e_op = 1; m_pend = 1;
      end else begin
        if (!m_pend && b_one.exists(b0)) begin
          tag = "R2"; e_len = 1; e_op = b_one[b0];
          if (e_op == 3) begin m_stop = 1; tag = "R3"; end
        end else if (m_pend ? x_two.exists(b0) : b_two.exists(b0)) begin
          tag = m_pend ? "R8" : "R5";
          e_fmt = 1; e_len = 2; e_op = m_pend ? x_two[b0] : b_two[b0];
          e_r1 = (b1 >> 4) & 15; e_r2 = b1 & 15;
        end else if (m_pend ? x_long.exists(b0 & 'hFC) : b_long.exists(b0 & 'hFC)) begin
          tag = m_pend ? "R8" : "R6";
          e_fmt = 2; e_len = (b1 & 'h10) ? 4 : 3;
          e_op = m_pend ? x_long[b0 & 'hFC] : b_long[b0 & 'hFC];
        end else begin
          tag = "R9"; e_fmt = 3; e_len = 1; e_inv = 1;
        end
        m_pend = 0;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    m_pend = 0; m_stop = 0;
    e_valid = 0; e_len = 0; e_fmt = 0; e_op = 0; e_ext = 0; e_r1 = 0; e_r2 = 0; e_inv = 0;
    compare("R10");
    rst_n = 1'b1;
  endtask

  initial begin
    fill_maps();
    @(negedge clk);
    do_reset();                   // R10
    cyc(0, 0, 0);                 // R11 idle
    // R5 R7 base register forms with field split
    cyc(1, 'h90, 'h45);
    cyc(1, 'hB8, 'h30);
    cyc(1, 'hAC, 'hF1);
    // R6 R7 long forms, both lengths, addressing bits set
    cyc(1, 'h03, 'h00);
    cyc(1, 'h03, 'h10);
    cyc(1, 'h6B, 'hFF);
    cyc(1, 'h3F, 'hEF);
    cyc(1, 'hF1, 'h00);           // R2 no-op
    // R4 R9 masked lookup must not catch two-byte misses
    cyc(1, 'h91, 'h00);
    cyc(1, 'hF3, 'h00);
    cyc(1, 'h04, 'h10);
    // R1 R8 prefix selects the extended map once
    cyc(1, 'hEE, 'h00);
    cyc(1, 'h90, 'h40);
    cyc(1, 'h90, 'h40);
    // R1 prefix survives idle cycles
    cyc(1, 'hEE, 'h00);
    cyc(0, 0, 0);
    cyc(0, 'h90, 0);
    cyc(1, 'h01, 'h10);
    // R1 double prefix stays extended, no invalid
    cyc(1, 'hEE, 0);
    cyc(1, 'hEE, 0);
    cyc(1, 'h7F, 'h00);
    // R9 invalid in the extended map clears the prefix
    cyc(1, 'hEE, 0);
    cyc(1, 'h91, 0);
    cyc(1, 'h90, 'h12);
    // R2 R9 one-byte base codes are invalid behind a prefix
    cyc(1, 'hEE, 0);
    cyc(1, 'hF1, 0);
    cyc(1, 'hEE, 0);
    cyc(1, 'hF2, 0);
    // R4 R7 R8 full sweep of both maps
    for (int b = 0; b < 256; b++) begin
      if (b != 'hF2) cyc(1, b, (b * 37) & 'hFF);
    end
    for (int b = 0; b < 256; b++) begin
      cyc(1, 'hEE, 0);
      cyc(1, b, (b * 53 + 16) & 'hFF);
    end
    // R3 halt freezes decoding until reset
    cyc(1, 'hF2, 0);
    cyc(1, 'h90, 'h11);
    cyc(1, 'hEE, 0);
    cyc(0, 0, 0);
    cyc(1, 'h03, 'h10);
    // R10 reset releases the halt
    do_reset();
    cyc(1, 'h90, 'h40);
    cyc(1, 'hEE, 0);
    do_reset();                   // R10 reset drops a pending prefix
    cyc(1, 'h90, 'h40);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule